// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

This block is a watchdog timer that runs from the processor clock. A prescaler divides the clock by one of two ratios. Its output steps a down-counter that spans 2^CNT_W counts. Software must refresh the counter before it runs out. A refresh is only accepted as an ordered pair of byte writes to the refresh register: a key byte of 00h, then a commit byte of FFh. A refresh that arrives too late lets the counter run past zero. That underflow is sent either to an interrupt pulse or to a reset-request pulse, chosen by a routing input.

A strap input is held steady across reset and sets the start behaviour. With the strap at 0, the timer starts counting by itself once reset is released. With the strap at 1, it stays stopped until software writes to the start register. A low-power hold input freezes the prescaler and the counter. When the hold is released, counting continues from the held value. The default parameters give a period of 16 × 32768 or 128 × 32768 clocks.

Top module: `refresh_watchdog`

## Requirements
- R1: While reset is asserted, the count reads all ones (2^CNT_W − 1), and neither output pulses.
- R2: While running, not held and not written, the count drops by one every DIV clocks. DIV is DIV_FAST when the period's latched divider select was 0, and DIV_SLOW when it was 1.
- R3: A write of 00h to the refresh register (wr_addr = 0), followed by FFh as the very next write to that register, reloads the count to all ones and restarts the prescaler from zero.
- R4: Any other write to the refresh register cancels a pending key, and a new sequence must start with 00h. An FFh with no 00h before it leaves the count running untouched.
- R5: With the strap at 0, counting begins without any register write once reset is released.
- R6: With the strap at 1, the count stays at all ones until a write of any value to the start register (wr_addr = 1). That write starts counting from all ones. Start writes made while already running are ignored.
- R7: While lp_hold is high, the count and the prescaler phase are frozen. Counting resumes from the held value when lp_hold falls.
- R8: A prescaler tick with the count at zero is an underflow. It gives a one-cycle pulse on irq_o when cfg_route_reset is 0, or on rst_req_o when it is 1, in the cycle after the tick. The count reloads to all ones and keeps running.
- R9: The divider select is sampled only when a period begins: the first cycle after reset, a start, a refresh, or an underflow reload. Changing it mid-period does not alter the current period.
- R10: A refresh or start accepted in the same cycle as an underflow tick takes priority, so no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 refresh, 1 start |
| wr_data | input | 8 | Write data byte |
| strap_wait_start | input | 1 | 1: stay stopped after reset until a start write |
| cfg_div_slow | input | 1 | Divider select: 0 DIV_FAST, 1 DIV_SLOW |
| cfg_route_reset | input | 1 | Underflow route: 0 interrupt, 1 reset request |
| lp_hold | input | 1 | Low-power hold, freezes counting |
| count_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | Underflow interrupt pulse |
| rst_req_o | output | 1 | Underflow reset-request pulse |

## Verification
The bench targets four kinds of fault:
- **Key sequence.** Stray bytes and an FFh with no key before it are sent. A sequencer that accepts a lone FFh would jump the count back to all ones.
- **Refresh racing the underflow.** A refresh is timed to land on the exact underflow tick. A design with the wrong priority would emit a spurious interrupt.
- **Divider select changed mid-period.** The select is flipped part-way through a period. A design that does not latch it would visibly speed up the count.
- **Stopped-state start.** The strap-1 start path is exercised, and a second start write is then sent mid-period. A design that honours the second start would reload the count early.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // register select encoding
    localparam logic ADDR_REFRESH = 1'b0;
    localparam logic ADDR_START   = 1'b1;

    // refresh key bytes
    localparam logic [7:0] KEY_ARM  = 8'h00;
    localparam logic [7:0] KEY_FIRE = 8'hFF;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    typedef enum logic {
        UF_TO_IRQ   = 1'b0,
        UF_TO_RESET = 1'b1
    } uf_route_e;

endpackage

// File: rtl/wdg_refresh_seq.sv
module wdg_refresh_seq
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output logic       refresh_hit,
    output logic       start_wr
);

    typedef struct packed {
        seq_state_e st;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        refresh_hit = 1'b0;
        start_wr    = wr_en && (wr_addr == ADDR_START);
        if (wr_en && (wr_addr == ADDR_REFRESH)) begin
            if (wr_data == KEY_ARM) begin
                seq_d.st = SEQ_ARMED;
            end else begin
                refresh_hit = (wr_data == KEY_FIRE) && (seq_q.st == SEQ_ARMED);
                seq_d.st    = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= SEQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int DIV_FAST = 16,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clear,
    input  logic restart,
    input  logic sel_in,
    output logic tick
);

    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int PRE_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(DIV_FAST - 1);
    localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(DIV_SLOW - 1);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
        logic             sel;
    } pre_reg_t;

    pre_reg_t pre_d, pre_q;
    logic [PRE_W-1:0] last_phase;

    // divider ratio in force for the current period
    always_comb begin
        last_phase = pre_q.sel ? LAST_SLOW : LAST_FAST;
    end

    always_comb begin
        tick = enable && !clear && (pre_q.phase == last_phase);
    end

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d.sel = sel_in;
        end
        if (clear) begin
            pre_d.phase = '0;
        end else if (enable) begin
            if (pre_q.phase == last_phase) begin
                pre_d.phase = '0;
            end else begin
                pre_d.phase = pre_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q.phase <= '0;
            pre_q.sel   <= 1'b0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             uflow
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_reg_t;

    cnt_reg_t cnt_d, cnt_q;

    always_comb begin
        uflow = tick && (cnt_q.value == '0);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.value = FULL;
        end else if (tick) begin
            if (cnt_q.value == '0) begin
                cnt_d.value = FULL;
            end else begin
                cnt_d.value = cnt_q.value - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.value <= FULL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.value;

endmodule

// File: rtl/refresh_watchdog.sv
module refresh_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int DIV_FAST = 16,
    parameter int DIV_SLOW = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             strap_wait_start,
    input  logic             cfg_div_slow,
    input  logic             cfg_route_reset,
    input  logic             lp_hold,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             rst_req_o
);

    typedef struct packed {
        logic run;
        logic fresh;
        logic irq;
        logic rrq;
    } ctl_reg_t;

    ctl_reg_t ctl_d, ctl_q;

    logic refresh_hit;
    logic start_wr;
    logic start_hit;
    logic reload;
    logic restart;
    logic tick;
    logic uflow;
    logic running;
    uf_route_e route;

    wdg_refresh_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .refresh_hit (refresh_hit),
        .start_wr    (start_wr)
    );

    always_comb begin
        start_hit = start_wr && !ctl_q.run;
        reload    = refresh_hit || start_hit;
        restart   = reload || ctl_q.fresh || uflow;
        running   = ctl_q.run;
        route     = uf_route_e'(cfg_route_reset);
    end

    wdg_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctl_q.run && !lp_hold),
        .clear   (reload),
        .restart (restart),
        .sel_in  (cfg_div_slow),
        .tick    (tick)
    );

    wdg_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reload),
        .tick  (tick),
        .count (count_o),
        .uflow (uflow)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.fresh = 1'b0;
        if (ctl_q.fresh) begin
            ctl_d.run = !strap_wait_start;
        end
        if (start_hit) begin
            ctl_d.run = 1'b1;
        end
        ctl_d.irq = uflow && (route == UF_TO_IRQ);
        ctl_d.rrq = uflow && (route == UF_TO_RESET);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.run   <= 1'b0;
            ctl_q.fresh <= 1'b1;
            ctl_q.irq   <= 1'b0;
            ctl_q.rrq   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_o     = ctl_q.irq;
    assign rst_req_o = ctl_q.rrq;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             lp_hold,
    input logic             running,
    input logic             refresh_hit,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o,
    input logic             rst_req_o
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R8

    AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o)); // R8

    AST_UF_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || rst_req_o) |-> (count_o == FULL && $past(count_o) == '0)); // R8

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_hold && !wr_en) |=> $stable(count_o)); // R7

    AST_REFRESH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_hit |=> (count_o == FULL)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && count_o != '0) |=>
        (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1)); // R2

    AST_STOPPED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(count_o)); // R6

endmodule

bind refresh_watchdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .lp_hold     (lp_hold),
    .running     (running),
    .refresh_hit (refresh_hit),
    .count_o     (count_o),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o)
);

// File: tb/refresh_watchdog_tb.sv
`timescale 1ns/1ps
module refresh_watchdog_tb;

    localparam int CW   = 4;
    localparam int DF   = 2;
    localparam int DS   = 4;
    localparam int FULL = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          strap = 1'b0;
    logic          dsel = 1'b0;
    logic          route = 1'b0;
    logic          hold = 1'b0;
    logic [CW-1:0] cnt;
    logic          irq;
    logic          rrq;

    int checks = 0;
    int fails = 0;
    int irq_seen = 0;
    int rrq_seen = 0;
    bit done = 0;

    // reference model state
    int m_cnt = FULL;
    int m_pre = 0;
    bit m_run = 0, m_div = 0, m_fresh = 1, m_armed = 0, m_irq = 0, m_rrq = 0, m_live = 0;

    always #2.5 clk = ~clk;

    refresh_watchdog #(.CNT_W(CW), .DIV_FAST(DF), .DIV_SLOW(DS)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .strap_wait_start (strap),
        .cfg_div_slow     (dsel),
        .cfg_route_reset  (route),
        .lp_hold          (hold),
        .count_o          (cnt),
        .irq_o            (irq),
        .rst_req_o        (rrq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit refr, strt, uf, nrun, ndiv;
        int last;
        if (!rst_n) begin
            m_cnt = FULL; m_pre = 0; m_run = 0; m_div = 0; m_fresh = 1;
            m_armed = 0; m_irq = 0; m_rrq = 0; m_live = 1;
        end else begin
            refr = 0; uf = 0; nrun = m_run; ndiv = m_div;
            strt = wr_en && wr_addr && !m_run;
            if (wr_en && !wr_addr) begin
                if (wr_data == 8'h00) m_armed = 1;
                else begin
                    refr = (wr_data == 8'hFF) && m_armed;
                    m_armed = 0;
                end
            end
            last = (m_div ? DS : DF) - 1;
            if (m_fresh) begin
                nrun = !strap;
                ndiv = dsel;
            end
            if (refr || strt) begin
                m_cnt = FULL; m_pre = 0; ndiv = dsel;
                if (strt) nrun = 1;
            end else if (m_run && !hold) begin
                if (m_pre == last) begin
                    m_pre = 0;
                    if (m_cnt == 0) begin
                        uf = 1; m_cnt = FULL; ndiv = dsel;
                    end else m_cnt--;
                end else m_pre++;
            end
            m_irq = uf && !route;
            m_rrq = uf && route;
            m_run = nrun; m_div = ndiv; m_fresh = 0;
        end
    end

    // cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            chk(cnt == CW'(m_cnt), "R2 count", cnt, m_cnt);
            chk(irq == m_irq, "R8 irq", irq, m_irq);
            chk(rrq == m_rrq, "R8 rst_req", rrq, m_rrq);
            if (irq) irq_seen++;
            if (rrq) rrq_seen++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0; strap = s;
        cyc(3);
        chk(cnt == FULL, "R1 count in reset", cnt, FULL);
        chk(!irq && !rrq, "R1 pulses in reset", irq + rrq, 0);
        rst_n = 1'b1;
        irq_seen = 0; rrq_seen = 0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        int c;
        @(negedge clk);
        // R5 free-running start, R8 interrupt route
        do_reset(1'b0);
        cyc(40);
        chk(irq_seen == 1, "R5 auto start gives irq", irq_seen, 1);
        chk(rrq_seen == 0, "R8 no rst_req in irq mode", rrq_seen, 0);

        // R3 key pair, R4 stray bytes
        wr(1'b0, 8'h00); wr(1'b0, 8'hFF);
        chk(cnt == FULL, "R3 refresh reload", cnt, FULL);
        cyc(20);
        wr(1'b0, 8'hFF);
        chk(cnt < 8, "R4 lone FFh ignored", cnt, 5);
        wr(1'b0, 8'h00); wr(1'b0, 8'h55); wr(1'b0, 8'hFF);
        chk(cnt < 8, "R4 broken pair ignored", cnt, 4);

        // R7 hold
        wr(1'b0, 8'h00); wr(1'b0, 8'hFF);
        cyc(6);
        hold = 1'b1;
        cyc(1);
        c = cnt;
        cyc(10);
        chk(cnt == c, "R7 frozen in hold", cnt, c);
        hold = 1'b0;
        cyc(4);
        chk(cnt < c && cnt >= c - 2, "R7 resumes from held", cnt, c - 2);

        // R10 refresh on the underflow tick
        wr(1'b0, 8'h00); wr(1'b0, 8'hFF);
        irq_seen = 0;
        cyc(30);
        wr(1'b0, 8'h00); wr(1'b0, 8'hFF);
        chk(cnt == FULL, "R10 refresh wins", cnt, FULL);
        cyc(3);
        chk(irq_seen == 0, "R10 no pulse", irq_seen, 0);

        // R8 reset-request route
        route = 1'b1;
        wr(1'b0, 8'h00); wr(1'b0, 8'hFF);
        irq_seen = 0; rrq_seen = 0;
        cyc(40);
        chk(rrq_seen == 1, "R8 rst_req pulse", rrq_seen, 1);
        chk(irq_seen == 0, "R8 irq silent", irq_seen, 0);
        route = 1'b0;

        // R6 strap-held stop
        do_reset(1'b1);
        cyc(50);
        chk(cnt == FULL, "R6 stopped", cnt, FULL);
        chk(irq_seen + rrq_seen == 0, "R6 no pulses", irq_seen + rrq_seen, 0);
        wr(1'b1, 8'h5A);
        chk(cnt == FULL, "R6 start loads full", cnt, FULL);
        cyc(20);
        c = cnt;
        chk(c < FULL, "R6 counting after start", c, FULL - 10);
        wr(1'b1, 8'h00);
        chk(cnt <= c, "R6 second start ignored", cnt, c);

        // R9 divider latched per period
        dsel = 1'b1;
        do_reset(1'b0);
        cyc(6);
        dsel = 1'b0;
        cyc(14);
        chk(cnt >= 10, "R9 slow period kept", cnt, 11);
        wr(1'b0, 8'h00); wr(1'b0, 8'hFF);
        cyc(10);
        chk(cnt <= 11, "R9 new period fast", cnt, 10);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule